// File: doc/BRIEF.md
# Doorbell Mailbox Console Bridge

This block sits between a host-side agent and a local-side agent and lets them trade console characters and short control messages. It holds two 32-bit mailboxes, one per direction, and two 32-bit doorbells, one per receiving side. A mailbox that reads nonzero is busy, and its top bit marks a valid character. A doorbell carries a message code: 0x1 liveness ping, 0x2 connect, 0x3 disconnect, 0x5 console data. A doorbell that is pending and enabled raises the interrupt of its receiving side.

The host works through a register port with a two-bit address. The local side is served by hardware. A receive engine decodes the local doorbell. It moves incoming characters into a circular buffer that the local agent drains through a pop interface. It throttles the host by leaving the inbound mailbox uncleared when the buffer is close to full. A transmit engine takes characters from the local agent, waits until the outbound mailbox is free, writes the flagged word and rings the host with a data code. After every line feed it sends a carriage return.

The receive engine has two states. RX_IDLE goes to RX_SERVICE when the local interrupt is raised. RX_SERVICE acts on the code, acknowledges the doorbell and always goes back to RX_IDLE. The transmit engine has three states. TX_IDLE goes to TX_WAIT when a character is offered. TX_WAIT writes the mailbox once it is free, then goes to TX_CR if the character was a line feed and to TX_IDLE otherwise. TX_CR writes the carriage return once the mailbox is free and goes to TX_IDLE.

Top module: `dbell_console_bridge`

## Requirements
- R1: After reset, both mailboxes and both doorbells read zero, both interrupts are low, the link is down, no character is available and the transmit side is ready.
- R2: Host address 0 is the inbound mailbox. A host write to it takes effect only while it reads zero; a write while it is nonzero leaves the stored word unchanged.
- R3: Host address 3 rings the local doorbell by ORing the written bits into it. Host address 2 reads the host doorbell, and writing ones there clears those bits. When the engine acknowledges the local doorbell, only the bits it serviced are cleared, so a ring in the same cycle survives.
- R4: The local status word carries, from high bit to low: local doorbell pending at bit 20, local enable at bits 17:16, host doorbell pending at bit 12, host enable at bits 9:8. Each interrupt is its doorbell's "nonzero" status ANDed with its "enable nonzero" status. The receive engine services the local doorbell only while the local interrupt is high.
- R5: A local doorbell holding 0x1 causes 0x1 to be ORed into the host doorbell.
- R6: A local doorbell holding 0x2 empties the receive buffer, drops the hold flag, clears the inbound mailbox and brings the link up.
- R7: A local doorbell holding 0x5 stores bits 7:0 of the inbound mailbox in the buffer. If at least 4 entries stay free after that, the mailbox is cleared in the same step.
- R8: If fewer than 4 entries stay free after a 0x5, the mailbox is held and a hold flag is set. The mailbox is cleared and the flag dropped only once more than 4 entries are free.
- R9: A local doorbell holding 0x3 takes the link down. Any other code is acknowledged and does nothing else.
- R10: The transmit engine writes a character to host address 1 only while that mailbox reads zero. It writes the character with bit 31 set and ORs 0x5 into the host doorbell in the same cycle.
- R11: A transmitted 0x0A is followed by a transmitted 0x0D, sent under the same mailbox-free rule.
- R12: The receive buffer returns characters in arrival order; rx_avail is high exactly while it holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_we | input | 1 | Host register write strobe |
| h_addr | input | 2 | Host register address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| host_irq | output | 1 | Host doorbell interrupt |
| l_csr_we | input | 1 | Local status word write strobe |
| l_csr_wdata | input | 32 | Local status word write data |
| l_csr_rdata | output | 32 | Local status word |
| loc_irq | output | 1 | Local doorbell interrupt |
| rx_avail | output | 1 | Receive buffer holds a character |
| rx_char | output | 8 | Oldest buffered character |
| rx_pop | input | 1 | Remove the oldest character |
| link_up | output | 1 | Link connected |
| tx_valid | input | 1 | Character offered for transmit |
| tx_char | input | 8 | Character to transmit |
| tx_ready | output | 1 | Transmit engine accepts a character |

## Verification
The collision that matters is the host ringing the local doorbell in the very cycle the receive engine acknowledges it. The bench times a second ring to land exactly on the RX_SERVICE edge of a data message. It then expects the new code to remain pending and to be serviced on its own afterwards. A second overlap is a buffer drain that frees space while the hold flag is set. The bench pops to exactly 4 free entries, expects the mailbox still held, then pops once more and expects the clear one cycle later.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam logic [31:0] MSG_ALIVE      = 32'h1;
    localparam logic [31:0] MSG_CONNECT    = 32'h2;
    localparam logic [31:0] MSG_DISCONNECT = 32'h3;
    localparam logic [31:0] MSG_DATA       = 32'h5;

    localparam logic [7:0] CHAR_LF = 8'h0A;
    localparam logic [7:0] CHAR_CR = 8'h0D;

    // host register map
    localparam logic [1:0] HA_MB_H2L   = 2'd0;
    localparam logic [1:0] HA_MB_L2H   = 2'd1;
    localparam logic [1:0] HA_DB_HOST  = 2'd2;
    localparam logic [1:0] HA_DB_LOCAL = 2'd3;

    // local status word bit positions
    localparam int CSR_LOC_PEND  = 20;
    localparam int CSR_LOC_EN    = 16;
    localparam int CSR_HOST_PEND = 12;
    localparam int CSR_HOST_EN   = 8;

    typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_CR} tx_state_e;
    typedef enum logic {RX_IDLE, RX_SERVICE} rx_state_e;
endpackage

// File: rtl/dbc_rx_ring.sv
module dbc_rx_ring #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [W-1:0]             push_data,
    input  logic                     pop,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     not_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt != CAP);
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= push_data;
    end

    assign rd_data   = mem[rptr];
    assign count     = cnt;
    assign not_empty = (cnt != '0);
endmodule

// File: rtl/dbc_tx_engine.sv
module dbc_tx_engine
    import dbc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_char,
    input  logic              mb_busy,
    output logic              tx_ready,
    output logic              mb_we,
    output logic [WORD_W-1:0] mb_wdata,
    output logic              ring_data
);
    tx_state_e         state_q, state_d;
    logic [CHAR_W-1:0] char_q;
    logic [CHAR_W-1:0] out_char;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            char_q  <= '0;
        end else begin
            state_q <= state_d;
            if (tx_valid && state_q == TX_IDLE) char_q <= tx_char;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (tx_valid) state_d = TX_WAIT;
            TX_WAIT: if (!mb_busy)
                         state_d = (char_q == CHAR_W'(CHAR_LF)) ? TX_CR : TX_IDLE;
            TX_CR:   if (!mb_busy) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_ready  = (state_q == TX_IDLE);
        mb_we     = (state_q != TX_IDLE) && !mb_busy;
        out_char  = (state_q == TX_CR) ? CHAR_W'(CHAR_CR) : char_q;
        mb_wdata  = {1'b1, {(WORD_W-1-CHAR_W){1'b0}}, out_char};
        ring_data = mb_we;
    end
endmodule

// File: rtl/dbell_console_bridge.sv
module dbell_console_bridge
    import dbc_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int FULL_MARGIN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_we,
    input  logic [1:0]  h_addr,
    input  logic [31:0] h_wdata,
    output logic [31:0] h_rdata,
    output logic        host_irq,
    input  logic        l_csr_we,
    input  logic [31:0] l_csr_wdata,
    output logic [31:0] l_csr_rdata,
    output logic        loc_irq,
    output logic        rx_avail,
    output logic [7:0]  rx_char,
    input  logic        rx_pop,
    output logic        link_up,
    input  logic        tx_valid,
    input  logic [7:0]  tx_char,
    output logic        tx_ready
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] HOLD_AT = CW'(DEPTH - FULL_MARGIN);
    localparam logic [CW-1:0] CAP     = CW'(DEPTH);

    logic [31:0]   mb_h2l, mb_l2h, db_loc, db_host;
    logic [1:0]    loc_en, host_en;
    logic          full_q, link_q;
    rx_state_e     rx_state_q, rx_state_d;
    logic [CW-1:0] rx_count;

    logic svc_ack, svc_push, svc_clr_mb, svc_flush, svc_set_full;
    logic svc_link_set, svc_link_clr, svc_ring_alive, full_release;
    logic hw_mb_h2l, hw_mb_l2h, hw_db_host, hw_db_loc;
    logic        tx_mb_we, tx_ring;
    logic [31:0] tx_mb_wdata;

    assign hw_mb_h2l  = h_we && (h_addr == HA_MB_H2L);
    assign hw_mb_l2h  = h_we && (h_addr == HA_MB_L2H);
    assign hw_db_host = h_we && (h_addr == HA_DB_HOST);
    assign hw_db_loc  = h_we && (h_addr == HA_DB_LOCAL);

    assign loc_irq  = (db_loc != '0) && (loc_en != '0);
    assign host_irq = (db_host != '0) && (host_en != '0);

    // receive engine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_state_q <= RX_IDLE;
        else        rx_state_q <= rx_state_d;
    end

    always_comb begin
        rx_state_d = rx_state_q;
        unique case (rx_state_q)
            RX_IDLE:    if (loc_irq) rx_state_d = RX_SERVICE;
            RX_SERVICE: rx_state_d = RX_IDLE;
            default:    rx_state_d = RX_IDLE;
        endcase
    end

    // receive engine: actions
    always_comb begin
        svc_ack = 1'b0; svc_push = 1'b0; svc_clr_mb = 1'b0; svc_flush = 1'b0;
        svc_set_full = 1'b0; svc_link_set = 1'b0; svc_link_clr = 1'b0;
        svc_ring_alive = 1'b0;
        if (rx_state_q == RX_SERVICE) begin
            svc_ack = 1'b1;
            unique case (db_loc)
                MSG_ALIVE:      svc_ring_alive = 1'b1;
                MSG_CONNECT: begin
                    svc_flush    = 1'b1;
                    svc_clr_mb   = 1'b1;
                    svc_link_set = 1'b1;
                end
                MSG_DISCONNECT: svc_link_clr = 1'b1;
                MSG_DATA: begin
                    svc_push = (rx_count != CAP);
                    if (rx_count >= HOLD_AT) svc_set_full = 1'b1;
                    else                     svc_clr_mb   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign full_release = full_q && (rx_count < HOLD_AT) && (rx_state_q == RX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_h2l  <= '0;
            mb_l2h  <= '0;
            db_loc  <= '0;
            db_host <= '0;
            loc_en  <= '0;
            host_en <= '0;
            full_q  <= 1'b0;
            link_q  <= 1'b0;
        end else begin
            if (hw_mb_h2l && mb_h2l == '0)      mb_h2l <= h_wdata;
            else if (svc_clr_mb || full_release) mb_h2l <= '0;

            if (tx_mb_we)       mb_l2h <= tx_mb_wdata;
            else if (hw_mb_l2h) mb_l2h <= h_wdata;

            db_host <= (db_host & ~(hw_db_host ? h_wdata : 32'h0))
                     | (svc_ring_alive ? MSG_ALIVE : 32'h0)
                     | (tx_ring ? MSG_DATA : 32'h0);
            db_loc  <= (db_loc & ~(svc_ack ? db_loc : 32'h0))
                     | (hw_db_loc ? h_wdata : 32'h0);

            if (l_csr_we) begin
                loc_en  <= l_csr_wdata[CSR_LOC_EN +: 2];
                host_en <= l_csr_wdata[CSR_HOST_EN +: 2];
            end

            if (svc_flush || full_release) full_q <= 1'b0;
            else if (svc_set_full)         full_q <= 1'b1;

            if (svc_link_set)      link_q <= 1'b1;
            else if (svc_link_clr) link_q <= 1'b0;
        end
    end

    always_comb begin
        l_csr_rdata = '0;
        l_csr_rdata[CSR_LOC_PEND]       = (db_loc != '0);
        l_csr_rdata[CSR_LOC_EN +: 2]    = loc_en;
        l_csr_rdata[CSR_HOST_PEND]      = (db_host != '0);
        l_csr_rdata[CSR_HOST_EN +: 2]   = host_en;
    end

    always_comb begin
        unique case (h_addr)
            HA_MB_H2L:  h_rdata = mb_h2l;
            HA_MB_L2H:  h_rdata = mb_l2h;
            HA_DB_HOST: h_rdata = db_host;
            default:    h_rdata = db_loc;
        endcase
    end

    assign link_up = link_q;

    dbc_rx_ring #(.DEPTH(DEPTH), .W(8)) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (svc_flush),
        .push      (svc_push),
        .push_data (mb_h2l[7:0]),
        .pop       (rx_pop),
        .rd_data   (rx_char),
        .count     (rx_count),
        .not_empty (rx_avail)
    );

    dbc_tx_engine #(.CHAR_W(8), .WORD_W(32)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_char   (tx_char),
        .mb_busy   (mb_l2h != '0),
        .tx_ready  (tx_ready),
        .mb_we     (tx_mb_we),
        .mb_wdata  (tx_mb_wdata),
        .ring_data (tx_ring)
    );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int CNT_W = 9,
    parameter int HOLD  = 252
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_svc,
    input logic             loc_irq,
    input logic             h_we,
    input logic [1:0]       h_addr,
    input logic [31:0]      h_wdata,
    input logic [31:0]      db_loc,
    input logic [31:0]      db_host,
    input logic [31:0]      mb_h2l,
    input logic [31:0]      mb_l2h,
    input logic             full_q,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_mb_we,
    input logic             link_up
);
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_svc && !(h_we && h_addr == 2'd3) |=> db_loc == 32'h0);

    p_ring_survives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_svc && h_we && h_addr == 2'd3 |=> db_loc == $past(h_wdata));

    p_mb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_h2l != 32'h0) && !rx_svc && !full_q |=> mb_h2l == $past(mb_h2l));

    p_irq_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_irq && !rx_svc |=> rx_svc);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && (rx_count < CNT_W'(HOLD)) && !rx_svc |=> !full_q && mb_h2l == 32'h0);

    p_connect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_svc && db_loc == 32'h2 |=> link_up && rx_count == '0);

    p_tx_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mb_we |=> mb_l2h[31] && db_host[2] && db_host[0]);
endmodule

bind dbell_console_bridge dbc_checker #(
    .CNT_W ($clog2(DEPTH) + 1),
    .HOLD  (DEPTH - FULL_MARGIN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_svc   (rx_state_q == dbc_pkg::RX_SERVICE),
    .loc_irq  (loc_irq),
    .h_we     (h_we),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .db_loc   (db_loc),
    .db_host  (db_host),
    .mb_h2l   (mb_h2l),
    .mb_l2h   (mb_l2h),
    .full_q   (full_q),
    .rx_count (rx_count),
    .tx_mb_we (tx_mb_we),
    .link_up  (link_up)
);

// File: tb/dbell_console_bridge_tb_top.sv
`timescale 1ns/1ps
module dbell_console_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0;
    logic [1:0]  h_addr = 2'd0;
    logic [31:0] h_wdata = 32'h0;
    logic [31:0] h_rdata;
    logic        host_irq;
    logic        l_csr_we = 1'b0;
    logic [31:0] l_csr_wdata = 32'h0;
    logic [31:0] l_csr_rdata;
    logic        loc_irq;
    logic        rx_avail;
    logic [7:0]  rx_char;
    logic        rx_pop = 1'b0;
    logic        link_up;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_char = 8'h0;
    logic        tx_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] rd;

    localparam logic [31:0] FLAG = 32'h8000_0000;

    // transmit vectors: {char[40:33], first mailbox word[32:1], cr follows[0]}
    localparam logic [40:0] TX_VEC [4] = '{
        {8'h41, 32'h8000_0041, 1'b0},
        {8'h0A, 32'h8000_000A, 1'b1},
        {8'h0D, 32'h8000_000D, 1'b0},
        {8'h7F, 32'h8000_007F, 1'b0}
    };

    always #2.5 clk = ~clk;

    dbell_console_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .host_irq(host_irq), .l_csr_we(l_csr_we),
        .l_csr_wdata(l_csr_wdata), .l_csr_rdata(l_csr_rdata), .loc_irq(loc_irq),
        .rx_avail(rx_avail), .rx_char(rx_char), .rx_pop(rx_pop), .link_up(link_up),
        .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic csr_wr(input logic [31:0] d);
        l_csr_wdata = d; l_csr_we = 1'b1;
        @(negedge clk);
        l_csr_we = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] c);
        host_wr(2'd0, FLAG | {24'h0, c});
        host_wr(2'd3, 32'h5);
        tick(2);
    endtask

    task automatic pop_one();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic tx_send(input logic [7:0] c);
        tx_valid = 1'b1; tx_char = c;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        host_rd(2'd0, rd); chk("R1 inbound mailbox", rd, 32'h0);
        host_rd(2'd1, rd); chk("R1 outbound mailbox", rd, 32'h0);
        chk("R1 irqs/link/avail/ready", {host_irq, loc_irq, link_up, rx_avail, tx_ready},
            {1'b0, 1'b0, 1'b0, 1'b0, 1'b1});

        // R4 status word layout: local enable only
        csr_wr(32'h0003_0000);
        chk("R4 status readback", l_csr_rdata, 32'h0003_0000);

        // R5 ping answered; R4 host irq gated by host enable
        host_wr(2'd3, 32'h1);
        tick(2);
        host_rd(2'd2, rd); chk("R5 ping answer", rd, 32'h1);
        chk("R4 host irq masked", {31'h0, host_irq}, 32'h0);
        chk("R4 host pending bit12", l_csr_rdata, 32'h0003_1000);
        csr_wr(32'h0003_0300);
        chk("R4 host irq enabled", {31'h0, host_irq}, 32'h1);
        host_wr(2'd2, 32'hFFFF_FFFF);
        chk("R3 write-one clears host doorbell", {31'h0, host_irq}, 32'h0);

        // R6 connect
        host_wr(2'd3, 32'h2);
        tick(2);
        chk("R6 link up", {31'h0, link_up}, 32'h1);

        // R7 data
        send_char(8'h48);
        host_rd(2'd0, rd); chk("R7 mailbox cleared", rd, 32'h0);
        chk("R7 char stored", {23'h0, rx_avail, rx_char}, {23'h0, 1'b1, 8'h48});
        pop_one();
        chk("R12 empty after pop", {31'h0, rx_avail}, 32'h0);

        // R2 write blocked while busy; R4 service gated by local enable
        csr_wr(32'h0000_0300);
        host_wr(2'd0, 32'h8000_0011);
        host_wr(2'd0, 32'h8000_0022);
        host_rd(2'd0, rd); chk("R2 busy mailbox write ignored", rd, 32'h8000_0011);
        host_wr(2'd3, 32'h5);
        chk("R4 local irq masked", {31'h0, loc_irq}, 32'h0);
        chk("R4 local pending bit20", {31'h0, l_csr_rdata[20]}, 32'h1);
        tick(3);
        host_rd(2'd0, rd); chk("R4 not serviced while masked", rd, 32'h8000_0011);
        csr_wr(32'h0003_0300);
        tick(3);
        host_rd(2'd0, rd); chk("R7 serviced after enable", rd, 32'h0);
        chk("R7 char 0x11", {24'h0, rx_char}, 32'h11);
        pop_one();

        // R3 ring lands on the acknowledge edge
        host_wr(2'd0, 32'h8000_0033);
        host_wr(2'd3, 32'h5);
        tick(1);
        host_wr(2'd3, 32'h1);
        host_rd(2'd3, rd); chk("R3 same-cycle ring survives ack", rd, 32'h1);
        tick(2);
        host_rd(2'd2, rd); chk("R3 surviving ping serviced", rd, 32'h1);
        host_wr(2'd2, 32'hFFFF_FFFF);
        while (rx_avail) pop_one();

        // R8 flow control and R12 ordering
        begin
            int early_bad = 0;
            for (int i = 0; i < 252; i++) begin
                send_char(i[7:0]);
                host_rd(2'd0, rd);
                if (rd != 32'h0) early_bad++;
            end
            chk("R8 cleared while 4 or more free", early_bad, 0);
        end
        send_char(8'd252);
        host_rd(2'd0, rd); chk("R8 held at 3 free", rd, FLAG | 32'd252);
        chk("R12 oldest first", {24'h0, rx_char}, 32'h0);
        pop_one();
        tick(1);
        host_rd(2'd0, rd); chk("R8 still held at 4 free", rd, FLAG | 32'd252);
        chk("R12 second char", {24'h0, rx_char}, 32'h1);
        pop_one();
        tick(1);
        host_rd(2'd0, rd); chk("R8 released at 5 free", rd, 32'h0);
        begin
            int order_bad = 0;
            for (int i = 2; i < 253; i++) begin
                if (rx_char != i[7:0]) order_bad++;
                pop_one();
            end
            chk("R12 arrival order", order_bad, 0);
            chk("R12 drained", {31'h0, rx_avail}, 32'h0);
        end

        // R6 connect flushes buffer
        send_char(8'h61);
        send_char(8'h62);
        host_wr(2'd3, 32'h2);
        tick(2);
        chk("R6 buffer emptied", {30'h0, rx_avail, link_up}, 32'h1);

        // R10/R11 transmit vectors
        for (int k = 0; k < 4; k++) begin
            tx_send(TX_VEC[k][40:33]);
            tick(1);
            host_rd(2'd1, rd); chk("R10 flagged word", rd, TX_VEC[k][32:1]);
            host_rd(2'd2, rd); chk("R10 data ring", rd, 32'h5);
            host_wr(2'd2, 32'hFFFF_FFFF);
            host_wr(2'd1, 32'h0);
            if (TX_VEC[k][0]) begin
                tick(1);
                host_rd(2'd1, rd); chk("R11 carriage return follows", rd, 32'h8000_000D);
                host_wr(2'd2, 32'hFFFF_FFFF);
                host_wr(2'd1, 32'h0);
            end
            chk("R11 back to ready", {31'h0, tx_ready}, 32'h1);
        end

        // R10 waits for a free mailbox
        tx_send(8'h78);
        tick(1);
        host_wr(2'd2, 32'hFFFF_FFFF);
        tx_send(8'h79);
        tick(3);
        host_rd(2'd1, rd); chk("R10 busy mailbox untouched", rd, 32'h8000_0078);
        chk("R10 not ready while waiting", {31'h0, tx_ready}, 32'h0);
        host_wr(2'd1, 32'h0);
        tick(1);
        host_rd(2'd1, rd); chk("R10 written after free", rd, 32'h8000_0079);
        host_wr(2'd2, 32'hFFFF_FFFF);
        host_wr(2'd1, 32'h0);

        // R9 unknown code then disconnect
        host_wr(2'd3, 32'h4);
        tick(2);
        chk("R9 unknown code acked", {31'h0, l_csr_rdata[20]}, 32'h0);
        host_rd(2'd2, rd); chk("R9 unknown code no ring", rd, 32'h0);
        chk("R9 unknown code keeps link", {31'h0, link_up}, 32'h1);
        host_wr(2'd3, 32'h3);
        tick(2);
        chk("R9 disconnect", {31'h0, link_up}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule